// File: doc/BRIEF.md
# Two-CPU Level-Sensitive Interrupt Router

This block gathers `32 * N_WORDS` level-sensitive interrupt sources and routes them to two processors. Each processor owns a bank of registers on a shared 32-bit register bus. A bank has read/write enable words, which act as a per-processor mask, and read-only status words, which show the raw source levels. Each processor has one parent interrupt output. That output goes high when any source is both active and enabled in that processor's bank.

Software decides which processor services a source by setting the source's enable bit in one bank and leaving it clear in the other. To move a source, software clears the bit in the old bank and sets it in the new one. The bus has no handshake. A write lands at the clock edge, and read data appears one cycle after the address.

`busAddr` is a word address: one unit selects one 32-bit register. A bank holds `2 * N_WORDS` consecutive words. The enable words come first and the status words follow. Bank 1 starts directly after bank 0. Inside each group the word order is reversed: the first word of the group covers the highest-numbered sources.

Top module: `l1_irq_ctrl`

## Requirements
- R1: The status word at bank offset `N_WORDS + k` returns the raw levels of sources `32*(N_WORDS-1-k)` to `32*(N_WORDS-1-k)+31`, with source `32*m+b` at bit b. This holds whether or not those sources are enabled, and the value is the same in both banks.
- R2: Bank c occupies word addresses `c*2*N_WORDS` to `c*2*N_WORDS + 2*N_WORDS - 1`. Offsets `0..N_WORDS-1` are enable words and offsets `N_WORDS..2*N_WORDS-1` are status words.
- R3: The enable word at bank offset k masks sources `32*(N_WORDS-1-k)` to `32*(N_WORDS-1-k)+31`, using the same bit positions as in R1.
- R4: A write to an enable word replaces all 32 bits of that word. There is no set or clear alias.
- R5: `cpuIrq[c]` is high in the cycle after some source is both active and enabled in bank c. It is low in the cycle after no such source remains, whether the source dropped or was disabled.
- R6: A write to one bank's enable word changes neither the other bank's enable words nor the other bank's `cpuIrq` bit. A source moves between processors by clearing its bit in one bank and setting it in the other.
- R7: After reset, every enable word reads zero, `cpuIrq` is `0`, and `busRdData` is zero.
- R8: A write to a status address changes no enable word and does not alter the status that is read back.
- R9: Any address at or beyond `2*2*N_WORDS` reads zero, and a write to such an address has no effect.
- R10: `busRdData` shows the register addressed in the previous cycle. An enable write is visible to a read issued in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | ADDR_W | Register word address |
| busWrEn | input | 1 | Write strobe for the addressed register |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, registered |
| irqSrc | input | 32*N_WORDS | Level-sensitive interrupt sources |
| cpuIrq | output | NUM_CPUS | Parent interrupt, one bit per processor |

## Verification
The hardest case to reach from the ports is the mapping from a single source to a single enable bit across the reversed word order, checked in each bank separately. A wrong word index would still pass any test that enables whole words or all sources at once. The stimulus therefore drives every source bit alone and then, for every source bit in each bank, enables only that bit while the other sources toggle around it. Moving a source between banks and writing to status or out-of-range addresses are checked by reading the enable words back and watching both parent lines.

// File: rtl/l1ic_pkg.sv
package l1ic_pkg;
  localparam int WORD_BITS = 32;
  localparam int MAX_WORDS = 4;
  localparam int MAX_CPUS  = 4;
  localparam int IDX_W     = $clog2(MAX_WORDS);
  localparam int CPU_W     = $clog2(MAX_CPUS);

  typedef enum logic [1:0] {
    RD_ZERO   = 2'd0,
    RD_ENABLE = 2'd1,
    RD_STATUS = 2'd2
  } rdSrc_e;

  // Strobes from the address decoder to the register datapath
  typedef struct packed {
    logic              enWrite;
    rdSrc_e            rdSrc;
    logic [CPU_W-1:0]  cpuSel;
    logic [IDX_W-1:0]  wordIdx;
  } regStrobe_t;
endpackage

// File: rtl/l1ic_ctrl.sv
module l1ic_ctrl
  import l1ic_pkg::*;
#(
  parameter int N_WORDS  = 4,
  parameter int NUM_CPUS = 2,
  parameter int ADDR_W   = 8
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output regStrobe_t        strobe
);
  localparam int OFF_W  = $clog2(2 * N_WORDS);
  localparam int SLOT_W = OFF_W - 1;
  localparam int BANK_W = ADDR_W - OFF_W;

  logic [OFF_W-1:0]  offs;
  logic [SLOT_W-1:0] slot;
  logic [BANK_W-1:0] bankNum;
  logic              inBank;
  logic              isStatus;

  assign offs     = busAddr[OFF_W-1:0];
  assign bankNum  = busAddr[ADDR_W-1:OFF_W];
  assign isStatus = offs[OFF_W-1];
  assign slot     = offs[SLOT_W-1:0];
  assign inBank   = int'(bankNum) < NUM_CPUS;

  always_comb begin
    strobe.cpuSel  = CPU_W'(bankNum);
    // reversed word order: the first slot of a group covers the top sources
    strobe.wordIdx = IDX_W'(N_WORDS - 1) - IDX_W'(slot);
    strobe.enWrite = busWrEn && inBank && !isStatus;
    if (!inBank)
      strobe.rdSrc = RD_ZERO;
    else if (isStatus)
      strobe.rdSrc = RD_STATUS;
    else
      strobe.rdSrc = RD_ENABLE;
  end
endmodule

// File: rtl/l1ic_datapath.sv
module l1ic_datapath
  import l1ic_pkg::*;
#(
  parameter int N_WORDS  = 4,
  parameter int NUM_CPUS = 2
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  regStrobe_t                     strobe,
  input  logic [WORD_BITS-1:0]           wrData,
  input  logic [WORD_BITS*N_WORDS-1:0]   irqSrc,
  output logic [WORD_BITS-1:0]           rdData,
  output logic [NUM_CPUS-1:0]            cpuIrq
);
  logic [WORD_BITS-1:0] enReg [NUM_CPUS][N_WORDS];
  logic [N_WORDS-1:0]   wordHit [NUM_CPUS];
  logic [NUM_CPUS-1:0]  pend;
  logic [NUM_CPUS-1:0]  enAny;
  logic [NUM_CPUS-1:0]  irqQ;
  logic [WORD_BITS-1:0] rdNext;
  logic [WORD_BITS-1:0] rdQ;

  // Enable register file: whole-word replace on a decoded write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CPUS; c++)
        for (int w = 0; w < N_WORDS; w++)
          enReg[c][w] <= '0;
    end else if (strobe.enWrite) begin
      for (int c = 0; c < NUM_CPUS; c++)
        for (int w = 0; w < N_WORDS; w++)
          if (int'(strobe.cpuSel) == c && int'(strobe.wordIdx) == w)
            enReg[c][w] <= wrData;
    end
  end

  // Per-bank pending reduction
  always_comb begin
    for (int c = 0; c < NUM_CPUS; c++) begin
      enAny[c] = 1'b0;
      for (int w = 0; w < N_WORDS; w++) begin
        wordHit[c][w] = |(irqSrc[WORD_BITS*w +: WORD_BITS] & enReg[c][w]);
        enAny[c]      = enAny[c] | (|enReg[c][w]);
      end
      pend[c] = |wordHit[c];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqQ <= '0;
    else       irqQ <= pend;
  end

  // Read mux, registered once
  always_comb begin
    rdNext = '0;
    case (strobe.rdSrc)
      RD_ENABLE: begin
        for (int c = 0; c < NUM_CPUS; c++)
          for (int w = 0; w < N_WORDS; w++)
            if (int'(strobe.cpuSel) == c && int'(strobe.wordIdx) == w)
              rdNext = enReg[c][w];
      end
      RD_STATUS: begin
        for (int w = 0; w < N_WORDS; w++)
          if (int'(strobe.wordIdx) == w)
            rdNext = irqSrc[WORD_BITS*w +: WORD_BITS];
      end
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdQ <= '0;
    else       rdQ <= rdNext;
  end

  assign rdData = rdQ;
  assign cpuIrq = irqQ;

  AST_RD_ZERO_OUTSIDE: assert property (@(posedge clk) disable iff (!rstN)
    strobe.rdSrc == RD_ZERO |=> rdData == '0); // R9

  for (genvar gc = 0; gc < NUM_CPUS; gc++) begin : g_cpuChk
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rstN)
      cpuIrq[gc] |-> $past(enAny[gc])); // R5
    AST_IRQ_QUIET_SOURCES: assert property (@(posedge clk) disable iff (!rstN)
      irqSrc == '0 |=> !cpuIrq[gc]); // R5
    for (genvar gw = 0; gw < N_WORDS; gw++) begin : g_wordChk
      AST_EN_HOLD_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
        !(strobe.enWrite && int'(strobe.cpuSel) == gc && int'(strobe.wordIdx) == gw)
        |=> $stable(enReg[gc][gw])); // R6
    end
  end

  for (genvar gw = 0; gw < N_WORDS; gw++) begin : g_statChk
    AST_STATUS_RAW: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.rdSrc == RD_STATUS && int'(strobe.wordIdx) == gw)
      |=> rdData == $past(irqSrc[WORD_BITS*gw +: WORD_BITS])); // R1
  end
endmodule

// File: rtl/l1_irq_ctrl.sv
module l1_irq_ctrl
  import l1ic_pkg::*;
#(
  parameter int N_WORDS  = 4,
  parameter int NUM_CPUS = 2,
  parameter int ADDR_W   = 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic [ADDR_W-1:0]            busAddr,
  input  logic                         busWrEn,
  input  logic [WORD_BITS-1:0]         busWrData,
  output logic [WORD_BITS-1:0]         busRdData,
  input  logic [WORD_BITS*N_WORDS-1:0] irqSrc,
  output logic [NUM_CPUS-1:0]          cpuIrq
);
  regStrobe_t strobe;

  l1ic_ctrl #(
    .N_WORDS (N_WORDS),
    .NUM_CPUS(NUM_CPUS),
    .ADDR_W  (ADDR_W)
  ) ctrl_i (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  l1ic_datapath #(
    .N_WORDS (N_WORDS),
    .NUM_CPUS(NUM_CPUS)
  ) dp_i (
    .clk   (clk),
    .rstN  (rstN),
    .strobe(strobe),
    .wrData(busWrData),
    .irqSrc(irqSrc),
    .rdData(busRdData),
    .cpuIrq(cpuIrq)
  );
endmodule

// File: tb/l1_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module l1_irq_ctrl_tb_top;
  localparam int NW   = 4;
  localparam int NC   = 2;
  localparam int AW   = 8;
  localparam int NSRC = 32 * NW;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic [AW-1:0]   busAddr = '0;
  logic            busWrEn = 1'b0;
  logic [31:0]     busWrData = '0;
  logic [31:0]     busRdData;
  logic [NSRC-1:0] irqSrc = '0;
  logic [NC-1:0]   cpuIrq;

  int nChecks = 0;
  int nErrors = 0;
  logic [31:0] mEn [NC][NW];

  always #2.5 clk = ~clk;

  l1_irq_ctrl #(.N_WORDS(NW), .NUM_CPUS(NC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .irqSrc(irqSrc), .cpuIrq(cpuIrq)
  );

  function automatic logic [AW-1:0] enAddr(int c, int w);
    return AW'(c * 2 * NW + (NW - 1 - w));
  endfunction
  function automatic logic [AW-1:0] stAddr(int c, int w);
    return AW'(c * 2 * NW + NW + (NW - 1 - w));
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErrors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrEn = 1'b0;
    @(negedge clk);
    d = busRdData;
  endtask

  task automatic setEn(input int c, input int w, input logic [31:0] v);
    busWrite(enAddr(c, w), v);
    mEn[c][w] = v;
  endtask

  function automatic logic [NC-1:0] expIrq();
    logic [NC-1:0] r = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if ((irqSrc[32*w +: 32] & mEn[c][w]) != 0) r[c] = 1'b1;
    return r;
  endfunction

  task automatic setSrc(input logic [NSRC-1:0] v);
    @(negedge clk);
    irqSrc = v;
    @(negedge clk);
  endtask

  task automatic checkAllEn(input string tag);
    logic [31:0] d;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) begin
        busRead(enAddr(c, w), d);
        chk(tag, d, mEn[c][w]);
      end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nErrors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) mEn[c][w] = '0;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk("R7 irq in reset", 32'(cpuIrq), 32'h0);
    chk("R7 rdData in reset", busRdData, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R7 irq after reset", 32'(cpuIrq), 32'h0);
    checkAllEn("R7 enable zero");

    // R2 R3 R10: distinct pattern in every enable word, read back next cycle
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        setEn(c, w, 32'h5A00_0000 ^ 32'(c << 12) ^ 32'(w << 4) ^ 32'(1 << (w + 8 * c)));
    checkAllEn("R2 R10 enable readback");

    // R4: whole-word replacement
    setEn(1, 2, 32'hFFFF_FFFF);
    setEn(1, 2, 32'h0000_00F0);
    busRead(enAddr(1, 2), d);
    chk("R4 word replace", d, 32'h0000_00F0);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) setEn(c, w, 32'h0);

    // R1: every source alone, raw status in both banks, no irq while disabled
    for (int i = 0; i < NSRC; i++) begin
      setSrc(NSRC'(1) << i);
      chk("R1 no irq when disabled", 32'(cpuIrq), 32'h0);
      busRead(stAddr(i % NC, i / 32), d);
      chk("R1 status bit", d, 32'h1 << (i % 32));
      busRead(stAddr((i + 1) % NC, (i / 32 + 1) % NW), d);
      chk("R1 other status word", d, 32'h0);
    end

    // R3 R5 R6: single enable bit per bank, other sources toggle around it
    for (int c = 0; c < NC; c++)
      for (int i = 0; i < NSRC; i++) begin
        setEn(c, i / 32, 32'h1 << (i % 32));
        setSrc(~(NSRC'(1) << i));
        chk("R3 other sources masked", 32'(cpuIrq), 32'h0);
        setSrc('1);
        chk("R5 R6 bit enabled", 32'(cpuIrq), 32'(expIrq()));
        setEn(c, i / 32, 32'h0);
        @(negedge clk);
        chk("R5 disable drops irq", 32'(cpuIrq), 32'h0);
      end

    // R5: one-cycle latency on rise and fall
    setEn(0, 1, 32'h0000_0100);
    setSrc('0);
    @(negedge clk);
    irqSrc = NSRC'(1) << 40;
    #1 chk("R5 no rise before edge", 32'(cpuIrq), 32'h0);
    @(negedge clk);
    chk("R5 rise after one edge", 32'(cpuIrq), 32'h1);
    irqSrc = '0;
    #1 chk("R5 no fall before edge", 32'(cpuIrq), 32'h1);
    @(negedge clk);
    chk("R5 fall after one edge", 32'(cpuIrq), 32'h0);

    // R6: move source 40 from bank 0 to bank 1
    setSrc(NSRC'(1) << 40);
    chk("R6 owned by cpu0", 32'(cpuIrq), 32'h1);
    setEn(0, 1, 32'h0);
    setEn(1, 1, 32'h0000_0100);
    @(negedge clk);
    chk("R6 moved to cpu1", 32'(cpuIrq), 32'h2);
    busRead(enAddr(0, 1), d);
    chk("R6 old bank cleared", d, 32'h0);

    // R8: writes to status addresses ignored
    setSrc(NSRC'(32'h1234_5678) << 64);
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++) busWrite(stAddr(c, w), 32'hFFFF_FFFF);
    checkAllEn("R8 enables untouched");
    busRead(stAddr(0, 2), d);
    chk("R8 status still raw", d, 32'h1234_5678);
    chk("R8 irq unchanged", 32'(cpuIrq), 32'(expIrq()));

    // R9: outside both banks
    for (int a = 2 * 2 * NW; a < (1 << AW); a++) begin
      busWrite(AW'(a), 32'hDEAD_BEEF);
      busRead(AW'(a), d);
      chk("R9 outside reads zero", d, 32'h0);
    end
    checkAllEn("R9 outside writes ignored");

    summary();
    $finish;
  end
endmodule